// File: doc/BRIEF.md
# Generate-Propagate Tree Adder

This block adds two unsigned WIDTH-bit operands and a carry-in, producing a WIDTH-bit sum and a carry-out. It contains no storage and no clock: the result follows the inputs combinationally. It is meant for datapaths where a ripple chain across the full width would set the cycle time.

Every bit position first classifies itself from its own two operand bits. It generates a carry when both bits are set. It passes its incoming carry through when exactly one bit is set. Otherwise it forces its carry-out to zero. These per-bit pairs feed a balanced binary tree of merge cells. On the way up, each cell summarises two adjacent ranges as one range. On the way down, the same cell takes the carry arriving at its range and hands the right carry to each half. Carry depth therefore grows with log2(WIDTH), not with WIDTH. Each sum bit is the exclusive-or of its two operand bits and the carry delivered to it.

Top module: `gp_tree_adder`

## Requirements
- R1: For every input combination, {c_o, sum_o} equals a_i + b_i + c_i computed as an unsigned value WIDTH+1 bits wide, with c_o as bit WIDTH.
- R2: When every bit position has exactly one operand bit set (a_i ^ b_i all ones), c_o equals c_i, and every bit of sum_o equals the inverse of c_i.
- R3: When bit WIDTH-1 of both a_i and b_i is 0, c_o is 0 whatever the lower bits and c_i are.
- R4: When bit WIDTH-1 of both a_i and b_i is 1, c_o is 1 whatever the lower bits and c_i are.
- R5: sum_o[0] equals a_i[0] ^ b_i[0] ^ c_i.
- R6: The block holds no state and has no clock. sum_o and c_o reflect new inputs within the same time step, with no clock edge in between.
- R7: WIDTH must be a power of two and at least 2; the function of R1 holds at every such width.
- R8: A carry generated at bit 0 (a_i[0] = b_i[0] = 1) travels through a range in which every higher bit propagates, up to c_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First unsigned addend |
| b_i | input | WIDTH | Second unsigned addend |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum, modulo 2^WIDTH |
| c_o | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The bench builds two copies of the adder. One uses WIDTH = 8, which makes every operand pair and both carry-in values reachable, so the three-level tree is covered for all 131072 inputs. The other uses WIDTH = 32 and is fed random operands alongside the 8-bit sweep. That copy covers a five-level tree, where the down-going carries cross many cell boundaries. At both widths, directed cases pin the all-propagate, top-kill, top-generate and bottom-generate patterns.

// File: rtl/gp_tree_pkg.sv
package gp_tree_pkg;

    // Carry behaviour of a contiguous bit range
    typedef struct packed {
        logic g;   // range emits a carry on its own
        logic p;   // range passes its incoming carry
    } gp_t;

    // Summary of {hi, lo} as a single range
    function automatic gp_t gp_join(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Carry leaving a range, given the carry entering it
    function automatic logic gp_carry(input gp_t rng, input logic cin);
        return rng.g | (rng.p & cin);
    endfunction

endpackage

// File: rtl/gp_bit_cell.sv
module gp_bit_cell
    import gp_tree_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    output gp_t  gp_o
);

    gp_t gp_d;

    always_comb begin
        gp_d.g = a_i & b_i;
        gp_d.p = a_i ^ b_i;
    end

    assign gp_o = gp_d;

endmodule

// File: rtl/gp_join_cell.sv
module gp_join_cell
    import gp_tree_pkg::*;
(
    input  gp_t  lo_i,
    input  gp_t  hi_i,
    input  logic cin_i,
    output gp_t  grp_o,
    output logic c_lo_o,
    output logic c_hi_o
);

    always_comb begin
        grp_o  = gp_join(hi_i, lo_i);
        c_lo_o = cin_i;
        c_hi_o = gp_carry(lo_i, cin_i);
    end

endmodule

// File: rtl/gp_sum_row.sv
module gp_sum_row #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] cy_i,
    output logic [WIDTH-1:0] sum_o
);

    logic [WIDTH-1:0] sum_d;

    always_comb begin
        sum_d = a_i ^ b_i ^ cy_i;
    end

    assign sum_o = sum_d;

endmodule

// File: rtl/gp_tree_adder.sv
module gp_tree_adder
    import gp_tree_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_o
);

    localparam int unsigned LEVELS = $clog2(WIDTH);

    // R7: only power-of-two widths form a balanced tree
    if (WIDTH < 2 || (1 << LEVELS) != WIDTH) begin : g_bad_width
        $error("gp_tree_adder: WIDTH must be a power of two, at least 2");
    end

    // Level 0 is the root, level LEVELS holds one node per bit
    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int unsigned CNT = 1 << l;

        gp_t [CNT-1:0]  gp;
        logic [CNT-1:0] cin;

        if (l == 0) begin : g_root_cin
            assign cin[0] = c_i;
        end else begin : g_child_cin
            assign cin = g_lvl[l-1].g_node.cdn;
        end

        if (l == LEVELS) begin : g_leaf
            for (genvar j = 0; j < CNT; j++) begin : g_bit
                gp_bit_cell u_bit (
                    .a_i  (a_i[j]),
                    .b_i  (b_i[j]),
                    .gp_o (gp[j])
                );
            end
        end else begin : g_node
            logic [2*CNT-1:0] cdn;
            for (genvar m = 0; m < CNT; m++) begin : g_join
                gp_join_cell u_join (
                    .lo_i   (g_lvl[l+1].gp[2*m]),
                    .hi_i   (g_lvl[l+1].gp[2*m+1]),
                    .cin_i  (cin[m]),
                    .grp_o  (gp[m]),
                    .c_lo_o (cdn[2*m]),
                    .c_hi_o (cdn[2*m+1])
                );
            end
        end
    end

    logic [WIDTH-1:0] bit_cy_d;
    assign bit_cy_d = g_lvl[LEVELS].cin;

    gp_sum_row #(.WIDTH(WIDTH)) u_sum (
        .a_i   (a_i),
        .b_i   (b_i),
        .cy_i  (bit_cy_d),
        .sum_o (sum_o)
    );

    assign c_o = gp_carry(g_lvl[0].gp[0], c_i);

endmodule

// File: rtl/gp_tree_adder_chk.sv
module gp_tree_adder_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             c_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             c_o
);

    logic [WIDTH:0] want_d;

    always_comb begin
        want_d = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
        if (!$isunknown({a_i, b_i, c_i, sum_o, c_o})) begin
            // R1
            total_sum_chk: assert ({c_o, sum_o} == want_d);
            // R2
            all_prop_chk: assert (!(&(a_i ^ b_i)) || (c_o == c_i && sum_o == {WIDTH{~c_i}}));
            // R3
            top_kill_chk: assert (a_i[WIDTH-1] || b_i[WIDTH-1] || !c_o);
            // R4
            top_gen_chk: assert (!(a_i[WIDTH-1] && b_i[WIDTH-1]) || c_o);
            // R5
            low_bit_chk: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ c_i));
        end
    end

endmodule

bind gp_tree_adder gp_tree_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/gp_tree_adder_bench.sv
module gp_tree_adder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    typedef struct {
        bit          wide;
        logic [31:0] a;
        logic [31:0] b;
        logic        ci;
        logic [32:0] expv;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [7:0]  a8 = '0, b8 = '0, s8;
    logic        c8 = 1'b0, co8;
    logic [31:0] a32 = '0, b32 = '0, s32;
    logic        c32 = 1'b0, co32;

    gp_tree_adder #(.WIDTH(8)) u_gp_tree_adder (
        .a_i(a8), .b_i(b8), .c_i(c8), .sum_o(s8), .c_o(co8)
    );

    gp_tree_adder #(.WIDTH(32)) u_gp_tree_adder_w32 (
        .a_i(a32), .b_i(b32), .c_i(c32), .sum_o(s32), .c_o(co32)
    );

    item_t sbq[$];
    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic report_fail(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_fail++;
        if (n_fail <= 20)
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
    endtask

    // Driver: applies operands and queues the reference result
    task automatic send(input bit wide, input logic [31:0] a, input logic [31:0] b,
                        input logic ci, input string tag);
        item_t it;
        it.wide = wide;
        it.a    = a;
        it.b    = b;
        it.ci   = ci;
        it.tag  = tag;
        if (wide) begin
            a32 = a; b32 = b; c32 = ci;
            it.expv = {1'b0, a} + {1'b0, b} + {32'b0, ci};
        end else begin
            a8 = a[7:0]; b8 = b[7:0]; c8 = ci;
            it.expv = {24'b0, ({1'b0, a[7:0]} + {1'b0, b[7:0]} + {8'b0, ci})};
        end
        sbq.push_back(it);
    endtask

    // Monitor: compares each queued item half a period later
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [32:0] act;
            it  = sbq.pop_front();
            act = it.wide ? {co32, s32} : {24'b0, co8, s8};
            n_vec++;
            if (act !== it.expv) report_fail(it.tag, act, it.expv);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Idle inputs: all-zero result at both widths
        @(posedge clk);
        send(0, 32'h0, 32'h0, 1'b0, "R1 idle zero 8b");
        send(1, 32'h0, 32'h0, 1'b0, "R1 idle zero 32b");

        // R2: full propagate passes c_i to c_o, sum is ~c_i everywhere
        @(posedge clk);
        send(0, 32'hAA, 32'h55, 1'b0, "R2 propagate cin=0 8b");
        send(1, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1, "R2 propagate cin=1 32b");
        @(posedge clk);
        send(0, 32'h3C, 32'hC3, 1'b1, "R2 propagate cin=1 8b");
        send(1, 32'h12345678, 32'hEDCBA987, 1'b0, "R2 propagate cin=0 32b");

        // R3: top bit kills
        @(posedge clk);
        send(0, 32'h7F, 32'h7F, 1'b1, "R3 top kill 8b");
        send(1, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, "R3 top kill 32b");

        // R4: top bit generates
        @(posedge clk);
        send(0, 32'h80, 32'h80, 1'b0, "R4 top generate 8b");
        send(1, 32'h80000000, 32'h80000000, 1'b0, "R4 top generate 32b");

        // R5: bit 0 from its own operands and c_i
        @(posedge clk);
        send(0, 32'h01, 32'h00, 1'b1, "R5 low bit 8b");
        send(1, 32'h00000000, 32'h00000001, 1'b0, "R5 low bit 32b");

        // R8: carry from bit 0 through an all-propagate upper range
        @(posedge clk);
        send(0, 32'h01, 32'hFF, 1'b0, "R8 bottom generate 8b");
        send(1, 32'h00000001, 32'hFFFFFFFF, 1'b0, "R8 bottom generate 32b");

        // R6: no clock edge needed; result visible one time unit later
        @(posedge clk);
        send(1, 32'hDEADBEEF, 32'h21524111, 1'b0, "R6 same-step 32b");
        #1;
        if ({co32, s32} !== 33'h100000000) report_fail("R6 same-step", {co32, s32}, 33'h100000000);
        else n_vec++;

        // R1/R7: 8-bit exhaustive sweep with 32-bit random alongside
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < 2; c++) begin
                    @(posedge clk);
                    send(0, 32'(a), 32'(b), c[0], "R1 exhaustive 8b");
                    send(1, $urandom, $urandom, 1'($urandom), "R7 random 32b");
                end
            end
        end

        @(posedge clk);
        @(posedge clk);
        finish_run();
    end

endmodule